// File: doc/BRIEF.md
# Multiplier-Free Bit-Serial FIR Filter

This block is a fixed-coefficient FIR filter with sixteen taps that computes each output without a single multiplier. Signed 12-bit samples arrive over a valid/ready handshake and are shifted into a sample history. The block then walks the bit positions of the stored samples, one position per clock and least significant first. In each clock the bits at that position across all taps form an address. The taps are split into four groups of four. Each group has a 16-entry table, and each entry holds the sum of the coefficients whose address bit is set. The four table outputs are added and fed to a shift-accumulator. This accumulator weights every bit-slice sum by its binary position and subtracts the slice taken from the sign bit.

The coefficients are elaboration-time parameters, and the table contents are derived from them when the design is built. The accumulator keeps the result at full precision. A parameterised window of that result is presented with a one-cycle valid pulse for every accepted sample. A sample can be accepted every 12 clocks, because the ready signal rises again during the final bit slice of the current sample.

Top module: `da_fir`

## Requirements
- R1: For each accepted sample x[n], the full-precision result equals the sum over k = 0..15 of COEF[k]·x[n−k]. Here COEF[0] weights the newest sample, and both samples and coefficients are two's complement.
- R2: A sample is taken only in a cycle where in_valid and in_ready are both high. in_ready is low in the cycle after an acceptance.
- R3: Each accepted sample produces exactly one out_valid pulse, lasting one cycle. The pulse appears 14 clock edges after the edge that accepted the sample.
- R4: in_ready is high during the last of the 12 bit-slice cycles. A source that holds in_valid high therefore gets one sample accepted every 12 cycles.
- R5: Synchronous reset (rst high) clears the sample history, the accumulator and the bit counter. After reset, in_ready is 1 and out_valid is 0, and the filter treats taps not yet filled as zero.
- R6: The slice from bit 11, the sign bit, is subtracted. The extreme inputs −2048 and +2047 therefore give exact results, and the accumulator never overflows.
- R7: out_data equals bits [OUT_LSB +: OUT_W] of the full-precision result.
- R8: Each of the four groups of taps uses its own 16-entry table, and their outputs are summed. With every address bit set, as for an input of −1 on all taps, the filter applies the sum of all sixteen coefficients.
- R9: in_valid asserted while in_ready is low has no effect. The sample history and later outputs are unchanged by the data presented in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Filter can take a sample this cycle |
| in_data | input | DW (12) | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | OUT_W | Window [OUT_LSB +: OUT_W] of the signed full-precision result |

## Verification
The bench drives impulse, step and sustained extreme inputs of +2047, −2048 and −1. A design that added the sign-bit slice instead of subtracting it would be wrong by a large margin on every negative sample. A table entry built with the wrong bit order within a group, or a tap history that runs in reverse, would show up against the asymmetric coefficient set used in the bench. The bench also measures acceptance spacing and output latency, so an off-by-one bit counter or a misplaced clear of the accumulator would be caught. It presents data while ready is low, and resets partway through a run, to expose a design that absorbs ignored samples or keeps stale history.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

   // Sum of the coefficients whose select bit is set; builds one table entry.
   function automatic int part_entry(input int sel, input int c0, input int c1,
                                     input int c2, input int c3);
      int acc;
      acc = 0;
      if ((sel & 1) != 0) acc = acc + c0;
      if ((sel & 2) != 0) acc = acc + c1;
      if ((sel & 4) != 0) acc = acc + c2;
      if ((sel & 8) != 0) acc = acc + c3;
      return acc;
   endfunction

endpackage

// File: rtl/da_tap_line.sv
module da_tap_line #(
   parameter int NTAPS = 16,
   parameter int DW    = 12,
   localparam int BW   = $clog2(DW)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             shift,
   input  logic [DW-1:0]    din,
   input  logic [BW-1:0]    bit_sel,
   output logic [NTAPS-1:0] slice
);
   logic [NTAPS-1:0][DW-1:0] taps_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         taps_q <= '0;
      end else if (shift) begin
         taps_q <= {taps_q[NTAPS-2:0], din};
      end
   end

   for (genvar k = 0; k < NTAPS; k++) begin : g_slice
      assign slice[k] = taps_q[k][bit_sel];
   end

   p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !shift |=> $stable(taps_q));

endmodule

// File: rtl/da_part_lut.sv
module da_part_lut #(
   parameter int LW = 14,
   parameter int C0 = 0,
   parameter int C1 = 0,
   parameter int C2 = 0,
   parameter int C3 = 0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [3:0]           addr,
   output logic signed [LW-1:0] q
);
   logic signed [LW-1:0] tbl [16];

   for (genvar e = 0; e < 16; e++) begin : g_entry
      localparam int VAL = da_fir_pkg::part_entry(e, C0, C1, C2, C3);
      assign tbl[e] = LW'(VAL);
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= tbl[addr];
   end

endmodule

// File: rtl/da_shift_acc.sv
module da_shift_acc #(
   parameter int SW  = 17,
   parameter int DW  = 12,
   localparam int AW = SW + DW
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_vld,
   input  logic                 in_first,
   input  logic                 in_sign,
   input  logic signed [SW-1:0] in_sum,
   output logic signed [AW-1:0] acc_q,
   output logic                 done
);
   logic signed [AW-1:0] base;
   logic signed [SW-1:0] top;
   logic signed [SW:0]   newtop;
   logic signed [AW:0]   wide;
   logic signed [AW:0]   shifted;

   always_comb begin
      base    = in_first ? '0 : acc_q;
      top     = $signed(base[AW-1:DW]);
      newtop  = in_sign ? ((SW+1)'(top) - (SW+1)'(in_sum))
                        : ((SW+1)'(top) + (SW+1)'(in_sum));
      wide    = {newtop, base[DW-1:0]};
      shifted = wide >>> 1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= in_vld && in_sign;
         if (in_vld) acc_q <= shifted[AW-1:0];
      end
   end

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
      in_vld |-> (shifted[AW] == shifted[AW-1]));

endmodule

// File: rtl/da_fir.sv
module da_fir #(
   parameter int NTAPS   = 16,
   parameter int DW      = 12,
   parameter int CW      = 12,
   parameter int COEF [NTAPS] = '{-12, -30, 15, 120, 310, 560, 790, 930,
                                  930, 790, 560, 310, 120, 15, -30, -12},
   parameter int OUT_W   = 16,
   parameter int OUT_LSB = 12,
   localparam int NGRP   = NTAPS / 4,
   localparam int LW     = CW + 2,
   localparam int SW     = CW + $clog2(NTAPS) + 1,
   localparam int AW     = SW + DW,
   localparam int BW     = $clog2(DW)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [DW-1:0]    in_data,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data
);
   if (NTAPS % 4 != 0) begin : g_bad_taps
      $error("NTAPS must be a multiple of four");
   end
   if (OUT_LSB + OUT_W > AW) begin : g_bad_window
      $error("output window exceeds full-precision width");
   end
   if (DW < 2) begin : g_bad_dw
      $error("DW must be at least 2");
   end

   // bit-slice sequencing
   logic          busy;
   logic [BW-1:0] cnt;
   logic          last_bit, accept;

   assign last_bit = busy && (cnt == BW'(DW - 1));
   assign in_ready = !busy || last_bit;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (accept) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (last_bit) begin
         busy <= 1'b0;
      end else if (busy) begin
         cnt <= cnt + 1'b1;
      end
   end

   // sample history and bit slice
   logic [NTAPS-1:0] slice;

   da_tap_line #(.NTAPS(NTAPS), .DW(DW)) u_taps (
      .clk(clk), .rst(rst), .shift(accept), .din(in_data),
      .bit_sel(cnt), .slice(slice)
   );

   // stage 1: partitioned tables
   logic [NGRP-1:0][LW-1:0] lut_q;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      logic signed [LW-1:0] q_g;
      da_part_lut #(.LW(LW), .C0(COEF[4*g]), .C1(COEF[4*g+1]),
                    .C2(COEF[4*g+2]), .C3(COEF[4*g+3])) u_lut (
         .clk(clk), .rst(rst), .addr(slice[4*g +: 4]), .q(q_g)
      );
      assign lut_q[g] = q_g;
   end

   logic s1_vld, s1_first, s1_sign;
   always_ff @(posedge clk) begin
      if (rst) begin
         s1_vld   <= 1'b0;
         s1_first <= 1'b0;
         s1_sign  <= 1'b0;
      end else begin
         s1_vld   <= busy;
         s1_first <= busy && (cnt == '0);
         s1_sign  <= last_bit;
      end
   end

   // stage 2: adder across groups
   logic signed [SW-1:0] grp_sum, s2_sum;
   logic                 s2_vld, s2_first, s2_sign;

   always_comb begin
      grp_sum = '0;
      for (int g = 0; g < NGRP; g++) begin
         grp_sum = grp_sum + SW'($signed(lut_q[g]));
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         s2_sum   <= '0;
         s2_vld   <= 1'b0;
         s2_first <= 1'b0;
         s2_sign  <= 1'b0;
      end else begin
         s2_sum   <= grp_sum;
         s2_vld   <= s1_vld;
         s2_first <= s1_first;
         s2_sign  <= s1_sign;
      end
   end

   // stage 3: positional weighting
   logic signed [AW-1:0] acc_q;

   da_shift_acc #(.SW(SW), .DW(DW)) u_acc (
      .clk(clk), .rst(rst), .in_vld(s2_vld), .in_first(s2_first),
      .in_sign(s2_sign), .in_sum(s2_sum), .acc_q(acc_q), .done(out_valid)
   );

   assign out_data = acc_q[OUT_LSB +: OUT_W];

   p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !in_ready);

   p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   p_ready_last_r4: assert property (@(posedge clk) disable iff (rst)
      (in_ready && $past(!in_ready)) |-> !out_valid);

endmodule

// File: tb/sim_da_fir.sv
module sim_da_fir;
   localparam int NT   = 16;
   localparam int DW   = 12;
   localparam int OLSB = 4;
   localparam int OW   = 24;
   localparam int CF [NT] = '{2047, -2048, 5, -7, 100, 300, -1, 0,
                              64, -500, 1000, 33, -33, 9, 1, -3};

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [DW-1:0] in_data = '0;
   logic          out_valid;
   logic [OW-1:0] out_data;

   always #10 clk = ~clk;

   da_fir #(.NTAPS(NT), .DW(DW), .CW(12), .COEF(CF),
            .OUT_W(OW), .OUT_LSB(OLSB)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0, n_bad = 0, n_out = 0, n_sent = 0;
   int hist [NT];
   logic [OW-1:0] q_val [$];
   int            q_cyc [$];
   string         q_req [$];
   int last_acc = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic send(input int x, input string req);
      longint full;
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = DW'(x);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      last_acc = cyc;
      n_sent++;
      for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      full = 0;
      for (int k = 0; k < NT; k++) full += longint'(CF[k]) * longint'(hist[k]);
      q_val.push_back(OW'(full >>> OLSB));
      q_cyc.push_back(last_acc);
      q_req.push_back(req);
   endtask

   task automatic drain();
      while (q_val.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         n_out++;
         if (q_val.size() == 0) begin
            check(1'b0, "R3 unexpected output", 1, 0);
         end else begin
            logic [OW-1:0] e;
            int c;
            string r;
            e = q_val.pop_front();
            c = q_cyc.pop_front();
            r = q_req.pop_front();
            check(out_data == e, {r, " R1 R7 value"}, longint'($signed(out_data)), longint'($signed(e)));
            check(cyc - c == 14, "R3 latency", cyc - c, 14);
         end
      end
   end

   initial begin
      logic [31:0] seed;
      int a0;
      for (int k = 0; k < NT; k++) hist[k] = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R5 reset state
      check(in_ready == 1'b1, "R5 ready after reset", in_ready, 1);
      check(out_valid == 1'b0, "R5 no output after reset", out_valid, 0);

      // impulse (R1)
      send(2047, "R1 impulse");
      for (int i = 0; i < NT + 1; i++) send(0, "R1 impulse tail");
      // step
      for (int i = 0; i < NT + 2; i++) send(100, "R1 step");
      // extremes (R6)
      for (int i = 0; i < NT + 2; i++) send(2047, "R6 max positive");
      for (int i = 0; i < NT + 2; i++) send(-2048, "R6 most negative");
      // all address bits set (R8)
      for (int i = 0; i < NT + 1; i++) send(-1, "R8 all ones");
      // R4 spacing on back-to-back transfers
      send(7, "R4 first");
      a0 = last_acc;
      send(-9, "R4 second");
      check(last_acc - a0 == 12, "R4 accept spacing", last_acc - a0, 12);
      // R9 data presented while busy is ignored
      send(555, "R9 base");
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         in_valid = 1'b1;
         in_data  = 12'h7A5;
         @(negedge clk);
         check(in_ready == 1'b0, "R9 ready low while busy", in_ready, 0);
      end
      in_valid = 1'b0;
      send(-321, "R9 follow");
      // pseudo-random
      seed = 32'h1234_5678;
      for (int i = 0; i < 40; i++) begin
         seed = seed * 32'd1103515245 + 32'd12345;
         send(int'($signed(seed[27:16])), "R1 random");
      end
      drain();
      // R5 reset mid-run clears history
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < NT; k++) hist[k] = 0;
      check(in_ready == 1'b1, "R5 ready after mid reset", in_ready, 1);
      check(out_valid == 1'b0, "R5 idle after mid reset", out_valid, 0);
      send(-2048, "R5 impulse after reset");
      for (int i = 0; i < 4; i++) send(0, "R5 tail after reset");
      drain();
      check(n_out == n_sent - 0, "R3 output count", n_out, n_sent);
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule